// File: doc/BRIEF.md
# Address Decode Window Unit

This unit maps the addresses of a memory engine's requests onto bus targets. It holds a set of programmable windows. Each window has a base with a target identifier and an attribute byte packed beside it, and a size that works at 64 KB granularity. Every requesting port has its own enable register. That register turns windows on or off for that port alone and gives each window a two-bit access field.

A request carries a port number and a 32-bit address. One clock later the unit returns one of three results. On success it gives the winning window, its target and its attribute. If a window matched but the port has no access to it, it flags a protection error. If nothing matched, it flags a miss. Configuration is written through a simple indexed register port, and the same port reads every register back combinationally. The first few windows also hold a remap register. That register is stored and read back but takes no part in decoding.

Register index map, with NW windows and NR remap registers:
- indices 0..NW-1 hold the window bases;
- indices NW..2NW-1 hold the window sizes;
- indices 2NW..2NW+NR-1 hold the remap registers;
- the per-port enable registers follow, one per port in port order.

Top module: `adw_decode_unit`

## Requirements
- R1: After reset, every register reads back as zero and every request returns an error with no hit.
- R2: A base register keeps all 32 bits. Bits [7:0] are the target and bits [15:8] the attribute. A size register keeps only bits [31:16], and its lower bits read as zero. An enable register keeps bits [NW-1:0], where bit i enables window i, and bits [16+2i+1:16+2i], the access field of window i. All its other bits read as zero.
- R3: A write to an index beyond the last enable register changes no register, and reading such an index returns zero.
- R4: Remap registers (indices 2NW..2NW+NR-1) store and return all 32 bits and have no effect on decoding.
- R5: An address hits window i when window i is enabled for the requesting port and (addr[31:16] & ~size[31:16]) equals (base[31:16] & ~size[31:16]).
- R6: When several windows hit, the lowest-numbered one wins.
- R7: Window enables and access fields come only from the enable register of the port named by the request. The other port's enable register has no effect.
- R8: If no window hits, the response has hit=0, window=0 and err=1. If the winning window's access field for the port is 0, the response has hit=1, window=i and err=1. Whenever err=1, target and attribute are zero.
- R9: On a hit with a nonzero access field, the response has err=0, window=i, target=base[7:0] and attribute=base[15:8].
- R10: A request is answered on the clock edge that samples it, so it is visible one cycle later. A cycle with no request gives a response that is all zero, including the valid bit.
- R11: A request sampled on the same edge as a register write is decoded with the register values from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_idx_i | input | IDX_W (5) | Register index to write |
| wr_data_i | input | 32 | Register write data |
| rd_idx_i | input | IDX_W (5) | Register index to read |
| rd_data_o | output | 32 | Combinational read data |
| req_valid_i | input | 1 | Request present this cycle |
| req_port_i | input | PORT_W (1) | Requesting port |
| req_addr_i | input | 32 | Request address |
| resp_valid_o | output | 1 | Response valid (one cycle after request) |
| resp_hit_o | output | 1 | A window matched |
| resp_win_o | output | WIN_W (3) | Index of winning window |
| resp_target_o | output | 8 | Target identifier of winner |
| resp_attr_o | output | 8 | Attribute of winner |
| resp_err_o | output | 1 | Miss or protection error |

## Verification
The bench uses the default parameters: eight windows, four remap registers and two ports. With these values the full enable register layout is in use, and windows can overlap so that lowest-index priority is exercised with real contention. Two ports allow the check that one port's enables are fully isolated from the other's. A random phase mixes writes to every index, including unmapped ones, with requests whose upper address nibble and size masks are chosen so that hits, overlaps and misses all occur often.

// File: rtl/adw_pkg.sv
package adw_pkg;
  localparam int ADDR_W   = 32;
  localparam int DATA_W   = 32;
  localparam int HI_LSB   = 16;
  localparam int HI_W     = ADDR_W - HI_LSB;
  localparam int FLD_W    = 8;
  localparam int ATTR_LSB = 8;
  localparam int ACC_LSB  = 16;
  localparam int ACC_W    = 2;

  typedef struct packed {
    logic [HI_W-1:0]  base_hi;
    logic [FLD_W-1:0] attr;
    logic [FLD_W-1:0] tgt;
    logic [HI_W-1:0]  mask_hi;
  } win_cfg_t;
endpackage

// File: rtl/adw_regs.sv
module adw_regs
  import adw_pkg::*;
#(
  parameter int NUM_WIN   = 8,
  parameter int NUM_REMAP = 4,
  parameter int NUM_PORTS = 2,
  parameter int IDX_W     = 5
) (
  input  logic                                   clk_i,
  input  logic                                   rst_ni,
  input  logic                                   wr_en_i,
  input  logic [IDX_W-1:0]                       wr_idx_i,
  input  logic [DATA_W-1:0]                      wr_data_i,
  input  logic [IDX_W-1:0]                       rd_idx_i,
  output logic [DATA_W-1:0]                      rd_data_o,
  output win_cfg_t [NUM_WIN-1:0]                 cfg_o,
  output logic [NUM_PORTS-1:0][NUM_WIN-1:0]      en_o,
  output logic [NUM_PORTS-1:0][ACC_W*NUM_WIN-1:0] acc_o
);
  localparam int SIZE_OFS  = NUM_WIN;
  localparam int REMAP_OFS = 2 * NUM_WIN;
  localparam int EN_OFS    = REMAP_OFS + NUM_REMAP;
  localparam int NREG      = EN_OFS + NUM_PORTS;

  logic [NUM_WIN-1:0][DATA_W-1:0]        base_q;
  logic [NUM_WIN-1:0][HI_W-1:0]          size_q;
  logic [NUM_REMAP-1:0][DATA_W-1:0]      remap_q;
  logic [NUM_PORTS-1:0][NUM_WIN-1:0]     en_q;
  logic [NUM_PORTS-1:0][ACC_W*NUM_WIN-1:0] acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q  <= '0;
      size_q  <= '0;
      remap_q <= '0;
      en_q    <= '0;
      acc_q   <= '0;
    end else if (wr_en_i) begin
      for (int w = 0; w < NUM_WIN; w++) begin
        if (wr_idx_i == IDX_W'(w))            base_q[w] <= wr_data_i;
        if (wr_idx_i == IDX_W'(SIZE_OFS + w)) size_q[w] <= wr_data_i[DATA_W-1:HI_LSB];
      end
      for (int r = 0; r < NUM_REMAP; r++)
        if (wr_idx_i == IDX_W'(REMAP_OFS + r)) remap_q[r] <= wr_data_i;
      for (int p = 0; p < NUM_PORTS; p++)
        if (wr_idx_i == IDX_W'(EN_OFS + p)) begin
          en_q[p]  <= wr_data_i[NUM_WIN-1:0];
          acc_q[p] <= wr_data_i[ACC_LSB +: ACC_W*NUM_WIN];
        end
    end
  end

  always_comb begin
    rd_data_o = '0;
    for (int w = 0; w < NUM_WIN; w++) begin
      if (rd_idx_i == IDX_W'(w))            rd_data_o = base_q[w];
      if (rd_idx_i == IDX_W'(SIZE_OFS + w)) rd_data_o = {size_q[w], {HI_LSB{1'b0}}};
    end
    for (int r = 0; r < NUM_REMAP; r++)
      if (rd_idx_i == IDX_W'(REMAP_OFS + r)) rd_data_o = remap_q[r];
    for (int p = 0; p < NUM_PORTS; p++)
      if (rd_idx_i == IDX_W'(EN_OFS + p)) begin
        rd_data_o[NUM_WIN-1:0]                 = en_q[p];
        rd_data_o[ACC_LSB +: ACC_W*NUM_WIN]    = acc_q[p];
      end
  end

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_cfg
    assign cfg_o[w].base_hi = base_q[w][DATA_W-1:HI_LSB];
    assign cfg_o[w].attr    = base_q[w][ATTR_LSB +: FLD_W];
    assign cfg_o[w].tgt     = base_q[w][FLD_W-1:0];
    assign cfg_o[w].mask_hi = size_q[w];
  end

  assign en_o  = en_q;
  assign acc_o = acc_q;

  p_unmapped_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && (int'(wr_idx_i) >= NREG)) |=>
      ($stable(base_q) && $stable(size_q) && $stable(remap_q) && $stable(en_q) && $stable(acc_q)));

  p_remap_isolated_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && (int'(wr_idx_i) >= REMAP_OFS) && (int'(wr_idx_i) < EN_OFS)) |=>
      ($stable(cfg_o) && $stable(en_o) && $stable(acc_o)));
endmodule

// File: rtl/adw_match.sv
module adw_match
  import adw_pkg::*;
#(
  parameter int NUM_WIN = 8
) (
  input  win_cfg_t [NUM_WIN-1:0] cfg_i,
  input  logic [NUM_WIN-1:0]     en_i,
  input  logic [HI_W-1:0]        addr_hi_i,
  output logic [NUM_WIN-1:0]     match_o
);
  for (genvar w = 0; w < NUM_WIN; w++) begin : g_cmp
    logic [HI_W-1:0] keep;
    assign keep       = ~cfg_i[w].mask_hi;
    assign match_o[w] = en_i[w] && ((addr_hi_i & keep) == (cfg_i[w].base_hi & keep));
  end
endmodule

// File: rtl/adw_prio.sv
module adw_prio #(
  parameter int NUM_WIN = 8,
  parameter int WIN_W   = 3
) (
  input  logic [NUM_WIN-1:0] req_i,
  output logic [NUM_WIN-1:0] gnt_o,
  output logic               any_o,
  output logic [WIN_W-1:0]   idx_o
);
  logic [NUM_WIN:0] below;
  assign below[0] = 1'b0;

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_chain
    assign gnt_o[w]     = req_i[w] & ~below[w];
    assign below[w + 1] = below[w] | req_i[w];
  end

  assign any_o = below[NUM_WIN];

  always_comb begin
    idx_o = '0;
    for (int w = 0; w < NUM_WIN; w++)
      if (gnt_o[w]) idx_o = idx_o | WIN_W'(w);
  end
endmodule

// File: rtl/adw_decode_unit.sv
module adw_decode_unit
  import adw_pkg::*;
#(
  parameter int NUM_WIN   = 8,
  parameter int NUM_REMAP = 4,
  parameter int NUM_PORTS = 2,
  localparam int IDX_W    = $clog2(2 * NUM_WIN + NUM_REMAP + NUM_PORTS),
  localparam int PORT_W   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
  localparam int WIN_W    = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [31:0]       wr_data_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [31:0]       rd_data_o,
  input  logic              req_valid_i,
  input  logic [PORT_W-1:0] req_port_i,
  input  logic [31:0]       req_addr_i,
  output logic              resp_valid_o,
  output logic              resp_hit_o,
  output logic [WIN_W-1:0]  resp_win_o,
  output logic [7:0]        resp_target_o,
  output logic [7:0]        resp_attr_o,
  output logic              resp_err_o
);
  win_cfg_t [NUM_WIN-1:0]                   cfg;
  logic [NUM_PORTS-1:0][NUM_WIN-1:0]        en_all;
  logic [NUM_PORTS-1:0][ACC_W*NUM_WIN-1:0]  acc_all;
  logic [NUM_WIN-1:0]                       en_sel, match, gnt;
  logic [ACC_W*NUM_WIN-1:0]                 acc_sel;
  logic [ACC_W-1:0]                         acc_win;
  logic [WIN_W-1:0]                         win_idx;
  logic                                     any_hit, err_c;
  logic                                     unused_addr_lo;

  assign unused_addr_lo = ^req_addr_i[HI_LSB-1:0];

  adw_regs #(
    .NUM_WIN(NUM_WIN), .NUM_REMAP(NUM_REMAP), .NUM_PORTS(NUM_PORTS), .IDX_W(IDX_W)
  ) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_idx_i, .wr_data_i, .rd_idx_i, .rd_data_o,
    .cfg_o(cfg), .en_o(en_all), .acc_o(acc_all)
  );

  // only the requesting port's enables and access fields take part
  always_comb begin
    en_sel  = '0;
    acc_sel = '0;
    for (int p = 0; p < NUM_PORTS; p++)
      if (req_port_i == PORT_W'(p)) begin
        en_sel  = en_all[p];
        acc_sel = acc_all[p];
      end
  end

  adw_match #(.NUM_WIN(NUM_WIN)) u_match (
    .cfg_i(cfg), .en_i(en_sel), .addr_hi_i(req_addr_i[ADDR_W-1:HI_LSB]), .match_o(match)
  );

  adw_prio #(.NUM_WIN(NUM_WIN), .WIN_W(WIN_W)) u_prio (
    .req_i(match), .gnt_o(gnt), .any_o(any_hit), .idx_o(win_idx)
  );

  assign acc_win = acc_sel[{win_idx, 1'b0} +: ACC_W];
  assign err_c   = !any_hit || (acc_win == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      resp_valid_o  <= 1'b0;
      resp_hit_o    <= 1'b0;
      resp_win_o    <= '0;
      resp_target_o <= '0;
      resp_attr_o   <= '0;
      resp_err_o    <= 1'b0;
    end else begin
      resp_valid_o  <= req_valid_i;
      resp_hit_o    <= req_valid_i && any_hit;
      resp_win_o    <= (req_valid_i && any_hit) ? win_idx : '0;
      resp_err_o    <= req_valid_i && err_c;
      resp_target_o <= (req_valid_i && !err_c) ? cfg[win_idx].tgt  : '0;
      resp_attr_o   <= (req_valid_i && !err_c) ? cfg[win_idx].attr : '0;
    end
  end

  p_gnt_onehot_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt));

  p_gnt_in_match_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt & ~match) == '0);

  p_miss_err_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && (match == '0)) |=> (resp_err_o && !resp_hit_o));

  p_err_no_data_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_err_o |-> (resp_target_o == '0 && resp_attr_o == '0));

  p_ok_implies_hit_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_valid_o && !resp_err_o) |-> resp_hit_o);

  p_valid_track_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> resp_valid_o);

  p_idle_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> (!resp_valid_o && !resp_hit_o && !resp_err_o));
endmodule

// File: tb/adw_decode_unit_test.sv
module adw_decode_unit_test;
  localparam int NW = 8;
  localparam int NR = 4;
  localparam int NP = 2;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [4:0]  wr_idx_i = '0;
  logic [31:0] wr_data_i = '0;
  logic [4:0]  rd_idx_i = '0;
  logic [31:0] rd_data_o;
  logic        req_valid_i = 1'b0;
  logic [0:0]  req_port_i = '0;
  logic [31:0] req_addr_i = '0;
  logic        resp_valid_o, resp_hit_o, resp_err_o;
  logic [2:0]  resp_win_o;
  logic [7:0]  resp_target_o, resp_attr_o;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  adw_decode_unit uut (
    .clk_i(clk), .rst_ni, .wr_en_i, .wr_idx_i, .wr_data_i, .rd_idx_i, .rd_data_o,
    .req_valid_i, .req_port_i, .req_addr_i, .resp_valid_o, .resp_hit_o,
    .resp_win_o, .resp_target_o, .resp_attr_o, .resp_err_o
  );

  // behavioural model
  logic [31:0] m_base [NW];
  logic [31:0] m_size [NW];
  logic [31:0] m_remap[NR];
  logic [31:0] m_en   [NP];
  logic [21:0] exp_resp = '0;

  function automatic logic [31:0] m_read(input int idx);
    if (idx < NW)               return m_base[idx];
    if (idx < 2*NW)             return m_size[idx-NW];
    if (idx < 2*NW+NR)          return m_remap[idx-2*NW];
    if (idx < 2*NW+NR+NP)       return m_en[idx-2*NW-NR];
    return 32'h0;
  endfunction

  task automatic model_edge();
    logic hit, err;
    logic [2:0] win;
    logic [7:0] tgt, attr;
    int idx;
    hit = 0; err = 0; win = 0; tgt = 0; attr = 0;
    if (req_valid_i) begin
      for (int i = NW-1; i >= 0; i--) begin
        logic [15:0] k;
        k = ~m_size[i][31:16];
        if (m_en[req_port_i][i] && ((req_addr_i[31:16] & k) == (m_base[i][31:16] & k))) begin
          hit = 1; win = 3'(i);
        end
      end
      if (!hit) err = 1;
      else if (m_en[req_port_i][16+2*win +: 2] == 2'b00) err = 1;
      else begin tgt = m_base[win][7:0]; attr = m_base[win][15:8]; end
    end
    exp_resp = {req_valid_i, hit, win, err, tgt, attr};
    if (wr_en_i) begin
      idx = int'(wr_idx_i);
      if (idx < NW)               m_base[idx] = wr_data_i;
      else if (idx < 2*NW)        m_size[idx-NW] = wr_data_i & 32'hFFFF_0000;
      else if (idx < 2*NW+NR)     m_remap[idx-2*NW] = wr_data_i;
      else if (idx < 2*NW+NR+NP)  m_en[idx-2*NW-NR] = wr_data_i & 32'hFFFF_00FF;
    end
  endtask

  task automatic step(input string tag);
    logic [21:0] act;
    logic [31:0] rexp;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    act = {resp_valid_o, resp_hit_o, resp_win_o, resp_err_o, resp_target_o, resp_attr_o};
    checks++;
    if (act !== exp_resp) begin
      failures++;
      $display("FAIL %s response actual=%h expected=%h", tag, act, exp_resp);
    end
    rexp = m_read(int'(rd_idx_i));
    checks++;
    if (rd_data_o !== rexp) begin
      failures++;
      $display("FAIL %s readback idx=%0d actual=%h expected=%h", tag, rd_idx_i, rd_data_o, rexp);
    end
  endtask

  task automatic wr(input int idx, input logic [31:0] data, input string tag);
    wr_en_i = 1; wr_idx_i = 5'(idx); wr_data_i = data; rd_idx_i = 5'(idx);
    step(tag);
    wr_en_i = 0;
  endtask

  task automatic rq(input int port, input logic [31:0] addr, input string tag);
    req_valid_i = 1; req_port_i = 1'(port); req_addr_i = addr;
    step(tag);
    req_valid_i = 0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog R10 actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < NW; i++) begin m_base[i] = 0; m_size[i] = 0; end
    for (int i = 0; i < NR; i++) m_remap[i] = 0;
    for (int i = 0; i < NP; i++) m_en[i] = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1;

    // R1: reset contents and behaviour
    for (int i = 0; i < 32; i++) begin rd_idx_i = 5'(i); step("R1"); end
    rq(0, 32'h0000_0000, "R1");
    rq(1, 32'hFFFF_FFFF, "R1");

    // R2: storage masks
    wr(8,  32'h1234_5678, "R2");
    wr(20, 32'hFFFF_FFFF, "R2");
    wr(21, 32'h5A5A_A5A5, "R2");
    wr(3,  32'hDEAD_BEEF, "R2");
    wr(8,  32'h0, "R2");
    wr(20, 32'h0, "R2");
    wr(21, 32'h0, "R2");
    wr(3,  32'h0, "R2");

    // R3: unmapped indices
    wr(22, 32'hFFFF_FFFF, "R3");
    wr(31, 32'hFFFF_FFFF, "R3");
    for (int i = 0; i < 32; i++) begin rd_idx_i = 5'(i); step("R3"); end

    // R5, R9: one 1 MB window on port 0
    wr(0,  32'h1000_AB05, "R5");
    wr(8,  32'h000F_FFFF, "R5");
    wr(20, 32'h0003_0001, "R5");
    rq(0, 32'h1000_0000, "R9");
    rq(0, 32'h100F_FFFF, "R5");
    rq(0, 32'h1010_0000, "R5");
    rq(0, 32'h0FFF_FFFF, "R5");

    // R4: remap stored but inert
    wr(16, 32'hCAFE_F00D, "R4");
    wr(19, 32'h1000_0000, "R4");
    rd_idx_i = 5'd16;
    rq(0, 32'h1004_0000, "R4");
    rq(0, 32'h2000_0000, "R4");

    // R6: overlap between windows 2 and 5
    wr(2,  32'h4000_2202, "R6");
    wr(10, 32'h00FF_FFFF, "R6");
    wr(5,  32'h4000_5505, "R6");
    wr(13, 32'h0000_FFFF, "R6");
    wr(20, 32'hFFFF_0025, "R6");
    rq(0, 32'h4000_1234, "R6");
    rq(0, 32'h4010_0000, "R6");
    wr(20, 32'hFFFF_0021, "R6");
    rq(0, 32'h4000_1234, "R6");

    // R7: port 1 enables only window 5; port 0 config untouched
    wr(21, 32'h0C00_0020, "R7");
    rq(1, 32'h4000_1234, "R7");
    rq(1, 32'h1000_0000, "R7");
    rq(0, 32'h1000_0000, "R7");

    // R8: miss and zero access
    wr(3,  32'h2000_1122, "R8");
    wr(11, 32'h0000_FFFF, "R8");
    wr(20, 32'h0000_0008, "R8");
    rq(0, 32'h2000_1234, "R8");
    rq(0, 32'h2001_0000, "R8");
    wr(20, 32'h0080_0008, "R8");
    rq(0, 32'h2000_1234, "R9");

    // R10: no request cycles
    step("R10");
    step("R10");

    // R11: write and request on the same edge
    wr_en_i = 1; wr_idx_i = 5'd3; wr_data_i = 32'h3000_7788;
    req_valid_i = 1; req_port_i = 0; req_addr_i = 32'h2000_0000;
    step("R11");
    wr_en_i = 0;
    rq(0, 32'h2000_0000, "R11");
    rq(0, 32'h3000_0000, "R11");

    // random mix across all requirements (R5 R6 R7 R8 R9)
    for (int n = 0; n < 600; n++) begin
      int sel;
      sel = int'($urandom_range(0, 99));
      wr_en_i = (sel < 25);
      wr_idx_i = 5'($urandom_range(0, 31));
      if (wr_idx_i < 5'd8)
        wr_data_i = {4'($urandom), 12'h000, 16'($urandom)};
      else if (wr_idx_i < 5'd16)
        case ($urandom_range(0, 3))
          0: wr_data_i = 32'h0FFF_FFFF;
          1: wr_data_i = 32'h00FF_FFFF;
          2: wr_data_i = 32'h0000_FFFF;
          default: wr_data_i = 32'hFFFF_FFFF;
        endcase
      else
        wr_data_i = $urandom;
      rd_idx_i = 5'($urandom_range(0, 31));
      req_valid_i = ($urandom_range(0, 3) != 0);
      req_port_i = 1'($urandom);
      req_addr_i = {4'($urandom), 28'($urandom)};
      step("R5");
    end
    wr_en_i = 0; req_valid_i = 0;
    step("R10");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule